// File: doc/BRIEF.md
# Serial SAR Converter Output Port

This block is the digital side of a 12-bit successive-approximation converter that talks to a host over three wires. The wires are an active-low select that also means shutdown, a serial clock driven by the host, and a data line that is either driven or released. A parallel sample input stands in for the analog conversion result.

All inputs are sampled on a fast system clock. When select drops while the serial clock is low, a frame starts. The first two falling serial-clock edges form the acquisition window, and the sample is captured on the second. From that edge on, the data line is driven. It carries one low lead bit, then the word from its top bit down, then the same word again from bit 1 upward, and then zeros until select is released. The lowest bit is shared by both passes.

A frame opened while the serial clock is high is refused. A fault flag is raised, and the line stays released until select goes high. An output-enable signal travels with the data bit so that the released state can be observed.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, `dout_oe` is 0, `dout` is 0 and `frame_err` is 0.
- R2: While `cs_n` is high the port is shut down. `dout_oe` is 0 from the next system clock on, including when select is raised in the middle of a frame, and falling serial-clock edges do not re-enable it.
- R3: After a valid frame start, `dout_oe` stays 0 through the first falling edge of `sclk` and through every rising edge. It becomes 1 only on the second falling edge.
- R4: On the second falling edge, `dout_oe` becomes 1 and `dout` carries a 0 lead bit.
- R5: Falling edges 3 to 14 present sample bits 11 down to 0, with bit 11 on edge 3.
- R6: Falling edges 15 to 25 present sample bits 1 up to 11, with bit 1 on edge 15.
- R7: From falling edge 26 on, `dout` is 0 and `dout_oe` stays 1 for as long as `cs_n` stays low.
- R8: If `cs_n` falls while `sclk` is high, `frame_err` becomes 1 and `dout_oe` stays 0 for any following serial clocks. `frame_err` returns to 0 once `cs_n` is high.
- R9: `sample_in` is captured on the second falling edge. Changes to it later in the same frame do not alter any bit that is shifted out.
- R10: A new falling edge of `cs_n` discards the previous frame's data. The new frame again waits two falling edges and then shifts the newly captured word.
- R11: `dout` changes only in response to a falling edge of `sclk` or a change of `cs_n`. It holds its value across rising edges of `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; high means shutdown |
| sample_in | input | 12 | Parallel stand-in for the conversion result |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | 1 when the data line is driven |
| frame_err | output | 1 | Frame refused because select fell with the clock high |

## Verification
The hardest state to reach is the refused frame. It needs the select falling edge to land while the serial clock is already high. The bench reaches it by raising the serial clock first and only then lowering select, and it keeps toggling the clock afterwards to show that the line never turns on. A second hard case is the capture instant. The bench changes the parallel input right after the lead bit, so a design that captured the sample late, or kept tracking it, would shift out the wrong pattern.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
   typedef enum logic [1:0] {
      ST_SHUT  = 2'd0,
      ST_ACQ   = 2'd1,
      ST_XFER  = 2'd2,
      ST_FAULT = 2'd3
   } frame_state_t;
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
   parameter int              WIDTH   = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] fall
);
   if (WIDTH < 1) begin : g_bad_width
      $error("sar_edge_det: WIDTH must be at least 1");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= RST_VAL[g];
         else        prev_q <= din[g];
      end
      assign fall[g] = prev_q & ~din[g];
   end
endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
   import sar_port_pkg::*;
#(
   parameter int NULL_FALL = 2,
   parameter int CNT_W     = 5,
   parameter int SAT_CNT   = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             cs_fall,
   input  logic             sclk,
   input  logic             sclk_fall,
   output frame_state_t     state,
   output logic [CNT_W-1:0] fall_cnt,
   output logic             latch_en
);
   frame_state_t     state_n;
   logic [CNT_W-1:0] cnt_n;

   always_comb begin
      state_n  = state;
      cnt_n    = fall_cnt;
      latch_en = 1'b0;
      if (cs_n) begin
         state_n = ST_SHUT;
         cnt_n   = '0;
      end else if (cs_fall) begin
         cnt_n   = '0;
         state_n = sclk ? ST_FAULT : ST_ACQ;
      end else if (sclk_fall && (state == ST_ACQ || state == ST_XFER)) begin
         if (fall_cnt != CNT_W'(SAT_CNT)) cnt_n = fall_cnt + 1'b1;
         if (state == ST_ACQ && fall_cnt == CNT_W'(NULL_FALL - 1)) begin
            state_n  = ST_XFER;
            latch_en = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_SHUT;
         fall_cnt <= '0;
      end else begin
         state    <= state_n;
         fall_cnt <= cnt_n;
      end
   end
endmodule

// File: rtl/sar_bit_select.sv
module sar_bit_select
   import sar_port_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int NULL_FALL  = 2,
   parameter int CNT_W      = 5,
   parameter bit REPEAT_LSB = 1'b1
) (
   input  frame_state_t      state,
   input  logic [CNT_W-1:0]  fall_cnt,
   input  logic [DATA_W-1:0] word,
   output logic              dout,
   output logic              dout_oe
);
   localparam int MSB_END = NULL_FALL + DATA_W;

   logic msb_bit, lsb_bit;

   always_comb begin
      msb_bit = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (fall_cnt == CNT_W'(MSB_END - i)) msb_bit = word[i];
      end
   end

   if (REPEAT_LSB) begin : g_repeat
      always_comb begin
         lsb_bit = 1'b0;
         for (int i = 1; i < DATA_W; i++) begin
            if (fall_cnt == CNT_W'(MSB_END + i)) lsb_bit = word[i];
         end
      end
   end else begin : g_zero_tail
      assign lsb_bit = 1'b0;
   end

   assign dout_oe = (state == ST_XFER);
   assign dout    = dout_oe & (msb_bit | lsb_bit);
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
   import sar_port_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int NULL_FALL  = 2,
   parameter bit REPEAT_LSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic [DATA_W-1:0] sample_in,
   output logic              dout,
   output logic              dout_oe,
   output logic              frame_err
);
   localparam int SAT_CNT = NULL_FALL + 2 * DATA_W;
   localparam int CNT_W   = $clog2(SAT_CNT + 1);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("sar_serial_port: DATA_W must be at least 2");
   end
   if (NULL_FALL < 1) begin : g_bad_null
      $error("sar_serial_port: NULL_FALL must be at least 1");
   end

   logic [1:0]        falls;
   frame_state_t      state;
   logic [CNT_W-1:0]  fall_cnt;
   logic              latch_en;
   logic [DATA_W-1:0] word_q;

   sar_edge_det #(.WIDTH(2), .RST_VAL(2'b10)) i_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({cs_n, sclk}),
      .fall  (falls)
   );

   sar_frame_seq #(.NULL_FALL(NULL_FALL), .CNT_W(CNT_W), .SAT_CNT(SAT_CNT)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .cs_fall   (falls[1]),
      .sclk      (sclk),
      .sclk_fall (falls[0]),
      .state     (state),
      .fall_cnt  (fall_cnt),
      .latch_en  (latch_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 word_q <= '0;
      else if (cs_n || falls[1])  word_q <= '0;
      else if (latch_en)          word_q <= sample_in;
   end

   sar_bit_select #(.DATA_W(DATA_W), .NULL_FALL(NULL_FALL), .CNT_W(CNT_W),
                    .REPEAT_LSB(REPEAT_LSB)) i_sel (
      .state    (state),
      .fall_cnt (fall_cnt),
      .word     (word_q),
      .dout     (dout),
      .dout_oe  (dout_oe)
   );

   assign frame_err = (state == ST_FAULT);
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk (
   input logic clk,
   input logic rst_n,
   input logic sclk,
   input logic cs_n,
   input logic dout,
   input logic dout_oe,
   input logic frame_err
);
   logic sclk_q, cs_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         sclk_q <= sclk;
         cs_q   <= cs_n;
      end
   end

   // R2
   shutdown_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !dout_oe);

   // R2
   drive_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> !$past(cs_n));

   // R4
   lead_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_oe) |-> !dout);

   // R8
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> !dout_oe);

   // R8
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> ($past(sclk) && $past(cs_q) && !$past(cs_n)));

   // R11
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !cs_q && !(sclk_q && !sclk)) |=> $stable(dout));
endmodule

bind sar_serial_port sar_serial_port_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sclk      (sclk),
   .cs_n      (cs_n),
   .dout      (dout),
   .dout_oe   (dout_oe),
   .frame_err (frame_err)
);

// File: tb/test_sar_serial_port.sv
module test_sar_serial_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic [11:0] sample_in = '0;
   logic        dout, dout_oe, frame_err;
   int          errors = 0;
   int          checks = 0;

   always #5 clk = ~clk;

   sar_serial_port i_sar_serial_port (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
      .sample_in(sample_in), .dout(dout), .dout_oe(dout_oe), .frame_err(frame_err)
   );

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic wait_neg(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // expected {oe, bit} after the n-th falling serial edge of a frame
   function automatic logic [1:0] expect_at(logic [11:0] w, int n);
      if (n < 2)        return 2'b00;
      else if (n == 2)  return 2'b10;
      else if (n <= 14) return {1'b1, w[14 - n]};
      else if (n <= 25) return {1'b1, w[n - 14]};
      else              return 2'b10;
   endfunction

   function automatic string tag_for(int n);
      if (n < 2)        return "R3";
      else if (n == 2)  return "R4";
      else if (n <= 14) return "R5";
      else if (n <= 25) return "R6";
      else              return "R7";
   endfunction

   task automatic open_frame();
      sclk = 1'b0; wait_neg(2);
      cs_n = 1'b0; wait_neg(2);
   endtask

   task automatic close_frame();
      cs_n = 1'b1; wait_neg(3);
   endtask

   // one serial clock period: rise, check hold, fall, check new bit
   task automatic pulse(logic [11:0] w, int n, bit do_check, string over);
      logic held;
      held = dout;
      sclk = 1'b1; wait_neg(2);
      if (do_check) check("R11 hold across rising edge", dout, held);
      if (do_check && n < 2) check("R3 released during window", dout_oe, 1'b0);
      wait_neg(2);
      sclk = 1'b0; wait_neg(2);
      if (do_check) begin
         logic [1:0] e;
         e = expect_at(w, n);
         check({over, tag_for(n), " enable"}, dout_oe, e[1]);
         check({over, tag_for(n), " data"},   dout,    e[0]);
      end
      wait_neg(2);
   endtask

   task automatic t_reset();
      check("R1 enable", dout_oe, 1'b0);
      check("R1 data", dout, 1'b0);
      check("R1 fault", frame_err, 1'b0);
   endtask

   task automatic t_full_frame(logic [11:0] w);
      sample_in = w;
      open_frame();
      check("R3 released at start", dout_oe, 1'b0);
      for (int n = 1; n <= 30; n++) pulse(w, n, 1'b1, "");
      close_frame();
      check("R2 released after close", dout_oe, 1'b0);
   endtask

   task automatic t_latch_ignore();
      logic [11:0] w;
      w = 12'h5A3;
      sample_in = w;
      open_frame();
      pulse(w, 1, 1'b1, "");
      pulse(w, 2, 1'b1, "");
      sample_in = ~w;
      for (int n = 3; n <= 26; n++) pulse(w, n, 1'b1, "R9 ");
      close_frame();
   endtask

   task automatic t_shutdown();
      sample_in = 12'hFFF;
      open_frame();
      for (int n = 1; n <= 6; n++) pulse(12'hFFF, n, 1'b0, "");
      check("R2 driving before abort", dout_oe, 1'b1);
      cs_n = 1'b1; wait_neg(2);
      check("R2 abort releases line", dout_oe, 1'b0);
      for (int n = 0; n < 4; n++) pulse(12'hFFF, 0, 1'b0, "");
      check("R2 clocks in shutdown", dout_oe, 1'b0);
      check("R2 data in shutdown", dout, 1'b0);
   endtask

   task automatic t_fault();
      sclk = 1'b1; wait_neg(2);
      cs_n = 1'b0; wait_neg(2);
      check("R8 fault raised", frame_err, 1'b1);
      for (int n = 0; n < 20; n++) begin
         sclk = 1'b0; wait_neg(4);
         check("R8 line released in fault", dout_oe, 1'b0);
         sclk = 1'b1; wait_neg(4);
      end
      check("R8 fault held", frame_err, 1'b1);
      cs_n = 1'b1; wait_neg(2);
      check("R8 fault cleared", frame_err, 1'b0);
      sclk = 1'b0; wait_neg(2);
   endtask

   task automatic t_restart();
      sample_in = 12'hC3C;
      open_frame();
      for (int n = 1; n <= 8; n++) pulse(12'hC3C, n, 1'b0, "");
      close_frame();
      sample_in = 12'h1E7;
      open_frame();
      check("R10 old data gone", dout_oe, 1'b0);
      for (int n = 1; n <= 27; n++) pulse(12'h1E7, n, 1'b1, "R10 ");
      close_frame();
   endtask

   initial begin : watchdog
      #1_500_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait_neg(3);
      t_reset();
      rst_n = 1'b1;
      wait_neg(2);
      t_reset();
      t_full_frame(12'hA5C);
      t_full_frame(12'h3F1);
      t_full_frame(12'h801);
      t_latch_ignore();
      t_shutdown();
      t_fault();
      t_restart();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule